// File: doc/BRIEF.md
# Link Data-Valid Monitor with Window Hysteresis

This block watches a recovered serial bit stream, one bit per strobe, and decides whether the link carries well-formed 8b/10b traffic. It splits the stream into fixed windows of 2^WIN_LOG2 accepted bits, which is 32768 bits by default. During each window it looks for two kinds of evidence. The first is a run of identical bits longer than the code allows. The second is a comma character, in either polarity.

When the last bit of a window is accepted, the block grades the window as good or bad and updates a registered `data_ok` flag. With `multi_sel` low, the flag follows the grade of each window directly. With `multi_sel` high, the flag changes only after a streak of HYST consecutive windows of the same grade, which is four by default. This keeps brief noise from toggling the flag.

Top module: `link_dv_monitor`

## Requirements
- R1: A window ends on the 2^WIN_LOG2-th cycle with `rx_vld` high since the previous window end. `data_ok` may change only on the clock edge that accepts the last bit of a window, so the new value is visible from the following cycle.
- R2: A run of more than RUN_MAX (5) consecutive identical accepted bits marks the current window bad. The run is counted across window edges.
- R3: A comma is the 7-bit sequence 0011111 or 1100000, with the oldest bit written first. It is checked at every accepted bit position once seven bits have arrived. A window in which no comma completes is bad.
- R4: With `multi_sel` low at a window end, `data_ok` becomes 1 if the window was good and 0 if it was bad.
- R5: With `multi_sel` high, `data_ok` drops to 0 only at the end of the HYST-th consecutive bad window.
- R6: With `multi_sel` high, `data_ok` rises to 1 only at the end of the HYST-th consecutive good window. A window of the other grade restarts the streak. The streak counters saturate at HYST.
- R7: Cycles with `rx_vld` low are ignored. The value of `rx_bit` in those cycles affects neither the window count, the run length nor comma detection.
- R8: After synchronous reset, `data_ok` is 0, both streak counters are 0 and the window count starts at zero.
- R9: `multi_sel` is sampled only at the window end. Changing it inside a window has no effect before that window end, and the streak counters are kept across a mode change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_bit | input | 1 | Recovered serial bit |
| rx_vld | input | 1 | Strobe: `rx_bit` is accepted this cycle |
| multi_sel | input | 1 | 0 = per-window response, 1 = streak hysteresis |
| data_ok | output | 1 | Registered link-valid flag |

## Verification
The hardest state to reach from the ports is a streak that is interrupted or carried over. Examples are three bad windows, then one good window, then three more bad windows, or a mode change made while a window is half received. A wrong counter reset or a wrong sampling moment in either case changes the flag only several windows later.

The bench reduces the window to 64 bits and builds every window from three fixed bit patterns: clean comma traffic, comma-free alternation and a long run of ones. The patterns are chosen so that no comma and no long run straddles a window edge. Each window is therefore graded exactly as intended, and the interleaved streak sequences can be scripted window by window. Some windows are sent with idle strobe gaps that carry inverted bits.

// File: rtl/link_dv_monitor.sv
module link_dv_monitor #(
  parameter int WIN_LOG2 = 15,
  parameter int RUN_MAX  = 5,
  parameter int HYST     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_bit,
  input  logic rx_vld,
  input  logic multi_sel,
  output logic data_ok
);
  localparam int RW = $clog2(RUN_MAX + 2);
  localparam int HW = $clog2(HYST + 1);
  localparam logic [RW-1:0] RUN_SAT = RW'(RUN_MAX + 1);
  localparam logic [RW-1:0] RUN_LIM = RW'(RUN_MAX);
  localparam logic [HW-1:0] HMAX    = HW'(HYST);

  logic [WIN_LOG2-1:0] bit_cnt;
  logic [5:0]          hist;
  logic [2:0]          fill;
  logic                prev;
  logic [RW-1:0]       run;
  logic                rlv_seen, com_seen;
  logic [HW-1:0]       good_cnt, bad_cnt;

  wire [6:0] win7      = {hist, rx_bit};
  wire       comma_now = rx_vld && fill == 3'd6 &&
                         (win7 == 7'b0011111 || win7 == 7'b1100000);

  logic [RW-1:0] run_nxt;
  always_comb begin
    if (run != '0 && rx_bit == prev)
      run_nxt = (run == RUN_SAT) ? RUN_SAT : run + 1'b1;
    else
      run_nxt = RW'(1);
  end

  wire rlv_now  = rx_vld && run_nxt > RUN_LIM;
  wire win_end  = rx_vld && (&bit_cnt);
  wire win_bad  = rlv_seen || rlv_now || !(com_seen || comma_now);

  wire [HW-1:0] good_nxt = win_bad ? '0 : (good_cnt == HMAX ? HMAX : good_cnt + 1'b1);
  wire [HW-1:0] bad_nxt  = !win_bad ? '0 : (bad_cnt == HMAX ? HMAX : bad_cnt + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      hist     <= '0;
      fill     <= '0;
      prev     <= 1'b0;
      run      <= '0;
      rlv_seen <= 1'b0;
      com_seen <= 1'b0;
      good_cnt <= '0;
      bad_cnt  <= '0;
      data_ok  <= 1'b0;
    end else if (rx_vld) begin
      bit_cnt <= bit_cnt + 1'b1;
      hist    <= win7[5:0];
      prev    <= rx_bit;
      run     <= run_nxt;
      if (fill != 3'd6) fill <= fill + 3'd1;
      if (win_end) begin
        rlv_seen <= 1'b0;
        com_seen <= 1'b0;
        good_cnt <= good_nxt;
        bad_cnt  <= bad_nxt;
        if (!multi_sel)            data_ok <= !win_bad;
        else if (bad_nxt == HMAX)  data_ok <= 1'b0;
        else if (good_nxt == HMAX) data_ok <= 1'b1;
      end else begin
        rlv_seen <= rlv_seen | rlv_now;
        com_seen <= com_seen | comma_now;
      end
    end
  end

  // R1
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(data_ok));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_vld |=> $stable(bit_cnt) && $stable(run) && $stable(hist));
  // R6
  streak_excl_chk: assert property (@(posedge clk) disable iff (rst)
    good_cnt == '0 || bad_cnt == '0);
  // R6
  streak_sat_chk: assert property (@(posedge clk) disable iff (rst)
    good_cnt <= HMAX && bad_cnt <= HMAX);
  // R4
  single_bad_chk: assert property (@(posedge clk) disable iff (rst)
    win_end && !multi_sel && win_bad |=> !data_ok);
  // R5
  multi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    win_end && multi_sel && win_bad && data_ok && bad_cnt < HMAX - 1'b1 |=> data_ok);
endmodule

// File: tb/tb_link_dv_monitor.sv
module tb_link_dv_monitor;
  localparam int WL = 6;
  localparam int WN = 1 << WL;
  localparam int GOOD = 0, NOCOM = 1, RLV = 2;
  localparam logic [19:0] PAT = 20'b0011111010_1100000101;

  logic clk = 0, rst = 1, rx_bit = 0, rx_vld = 0, multi_sel = 0;
  logic data_ok;
  int checks = 0, errors = 0;
  int gcnt = 0, bcnt = 0;
  logic exp_ok = 0;
  logic q[$];
  string tags[$];

  always #4 clk = ~clk;

  link_dv_monitor #(.WIN_LOG2(WL)) dut (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_vld(rx_vld),
    .multi_sel(multi_sel), .data_ok(data_ok));

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s data_ok=%0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic logic pick(input int kind, input int i);
    if (kind == GOOD)  return i < 60 ? PAT[19 - (i % 20)] : logic'(i % 2);
    if (kind == NOCOM) return logic'(i % 2);
    return i < 20 ? PAT[19 - i] : 1'b1;
  endfunction

  task automatic win(input int kind, input logic msel, input bit gaps, input string tag);
    logic bad;
    for (int i = 0; i < WN; i++) begin
      if (i == 20) multi_sel = msel;
      if (i == 32) chk(data_ok, exp_ok, "R1 mid-window hold");
      if (gaps && i % 7 == 3) begin
        @(negedge clk); rx_vld = 0; rx_bit = ~pick(kind, i);
      end
      @(negedge clk); rx_vld = 1; rx_bit = pick(kind, i);
    end
    @(negedge clk); rx_vld = 0;
    bad = (kind != GOOD);
    if (bad) begin gcnt = 0; bcnt = bcnt < 4 ? bcnt + 1 : 4; end
    else     begin bcnt = 0; gcnt = gcnt < 4 ? gcnt + 1 : 4; end
    if (!msel) exp_ok = !bad;
    else if (bcnt == 4) exp_ok = 0;
    else if (gcnt == 4) exp_ok = 1;
    q.push_back(exp_ok);
    tags.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      wait (q.size() != 0);
      chk(data_ok, q.pop_front(), tags.pop_front());
    end
  end

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(data_ok, 1'b0, "R8 reset value");
    // single-window mode
    win(GOOD,  0, 0, "R4 good window");
    win(NOCOM, 0, 0, "R3 no comma -> bad");
    win(GOOD,  0, 1, "R7 gaps ignored, good");
    win(RLV,   0, 0, "R2 long run -> bad");
    win(GOOD,  0, 0, "R4 recover");
    win(NOCOM, 0, 1, "R7 gaps, no comma");
    win(GOOD,  0, 0, "R4 recover again");
    // multi-window mode, selected mid-window
    win(NOCOM, 1, 0, "R9 mode at boundary, bad 1");
    win(RLV,   1, 0, "R5 bad 2");
    win(GOOD,  1, 0, "R6 good breaks streak");
    win(NOCOM, 1, 0, "R5 bad 1");
    win(NOCOM, 1, 0, "R5 bad 2");
    win(RLV,   1, 0, "R5 bad 3");
    win(NOCOM, 1, 0, "R5 bad 4 drops");
    win(NOCOM, 1, 0, "R6 saturated bad");
    win(GOOD,  1, 0, "R6 good 1");
    win(GOOD,  1, 1, "R6 good 2");
    win(GOOD,  1, 0, "R6 good 3");
    win(RLV,   1, 0, "R6 bad restarts");
    win(GOOD,  1, 0, "R6 good 1");
    win(GOOD,  1, 0, "R6 good 2");
    win(GOOD,  1, 0, "R6 good 3");
    // counters kept across mode change
    win(GOOD,  0, 0, "R9 single, good 4");
    win(NOCOM, 1, 0, "R9 multi hold");
    win(NOCOM, 1, 0, "R9 bad 2");
    win(NOCOM, 0, 0, "R9 single bad 3");
    win(NOCOM, 1, 0, "R9 kept streak bad 4");
    win(GOOD,  1, 0, "R6 good 1 stays low");
    @(negedge clk);
    wait (q.size() == 0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule